// File: doc/BRIEF.md
# Deserializer Lane Calibration Sequencer

This block drives the start-up alignment of a group of deserializer lanes. After the clock generator reports lock and a correctly sized launch pulse arrives, it asks the remote transmitter for a training pattern. Once the transmitter acknowledges, it works through the lanes one at a time. For each lane it steps the input delay tap across its full range and records where the sampled word is some rotation of the training word. It then programs the centre of the widest such run of taps. After that it steps the word-boundary slip until the parallel word equals the training word exactly.

The analog delay line and the serial-to-parallel shifter are outside this block. The block drives a tap value and a slip count for each lane and reads back that lane's parallel word. Delay taps are written only on a quarter-rate tick, which stands for the slower clock of the delay registers. The block ends in a done state when every lane is aligned. It ends in an error state when no usable tap window or word boundary is found.

Top module: `lane_cal_seq`

## Requirements
- R1: `rst_out` is 1 during reset and in the cycle after any cycle with `pll_locked` low. It is 0 one cycle after `pll_locked` is seen high. No calibration is accepted while `rst_out` is 1.
- R2: A launch is accepted only when `launch` has been high for between LAUNCH_MIN (2) and LAUNCH_MAX (16) consecutive cycles, inclusive. It is judged in the first low cycle after the pulse. Shorter and longer pulses leave `train_req` low.
- R3: `train_req` rises on the clock edge that accepts a launch. It stays high until the block reaches done, error or an abort.
- R4: While `train_req` is high and `train_ack` has not yet been seen, no lane tap changes. Every lane keeps its default tap DEF_TAP (8).
- R5: A lane tap changes only on the clock edge that follows a cycle with `dly_tick` high. `dly_tick` is high in one cycle of every four.
- R6: In the sweep, a tap is a hit when, SETTLE cycles after the tap write, the lane word equals any left-rotation of TRAIN_WORD (0xA5). The tap finally programmed is start + (len-1)/2 of the longest run of consecutive hit taps. Among runs of equal length, the lowest-starting run wins.
- R7: If the longest run is shorter than MIN_WIN (3) taps, the block ends with `cal_error` high and both `train_req` and `cal_done` low.
- R8: Word alignment tries slip counts 0, 1, ... WORD_W-1 in that order, each for SETTLE cycles. The first slip at which the lane word equals TRAIN_WORD stays on that lane's `lane_slip` field. Lane k occupies bits k*TAP_W and k*SLIP_W of the packed vectors.
- R9: If no slip count yields TRAIN_WORD, the block ends with `cal_error` high and `cal_done` low.
- R10: `cal_done` rises only after every lane has been tap- and word-aligned while `train_ack` is high. It stays high, even after `train_ack` falls, until the next accepted launch or loss of lock.
- R11: If `train_ack` falls during sweep or word alignment, the block returns to idle on the next edge with `train_req`, `cal_done` and `cal_error` all low.
- R12: Loss of lock in any state returns the block to idle on the next edge, with `train_req`, `cal_done` and `cal_error` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_locked | input | 1 | Clock generator lock indication |
| launch | input | 1 | Calibration launch pulse |
| train_ack | input | 1 | Transmitter is sending the training word |
| lane_word | input | LANES*WORD_W | Parallel word returned by each lane |
| rst_out | output | 1 | High while the clock generator is unlocked |
| train_req | output | 1 | Request for the training word |
| dly_tick | output | 1 | Quarter-rate delay-register write tick |
| lane_tap | output | LANES*TAP_W | Input delay tap per lane |
| lane_slip | output | LANES*SLIP_W | Word-boundary slip per lane |
| cal_done | output | 1 | All lanes aligned |
| cal_error | output | 1 | Calibration failed |

## Verification
Several rules are checked on every cycle. Taps move only after a tick, taps stay still while waiting for the acknowledge, and an acknowledge drop or loss of lock clears the request and both result flags. Done may rise only with the acknowledge present, and error only out of an active request. Only the bench scenarios can show the rest. These are the numeric choice of the centre tap for single, split and tied windows, the slip that is finally kept, the exact launch-width bounds, and the two distinct failure paths. Each depends on the lane word that the bench's lane model feeds back.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [3:0] {
    S_IDLE      = 4'd0,
    S_WAIT_ACK  = 4'd1,
    S_SW_SET    = 4'd2,
    S_SW_SETTLE = 4'd3,
    S_SW_END    = 4'd4,
    S_CTR_SET   = 4'd5,
    S_SL_SETTLE = 4'd6,
    S_DONE      = 4'd7,
    S_ERR       = 4'd8
  } cal_state_e;
endpackage

// File: rtl/lcs_launch_filter.sv
module lcs_launch_filter #(
  parameter int LAUNCH_MIN = 2,
  parameter int LAUNCH_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic launch_ok
);
  localparam int CNT_W = $clog2(LAUNCH_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LAUNCH_MAX + 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  // Pulse width is judged in the first low cycle after the pulse.
  assign launch_ok = prev_q && !launch &&
                     (cnt_q >= CNT_W'(LAUNCH_MIN)) && (cnt_q <= CNT_W'(LAUNCH_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= launch;
      if (launch) begin
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lcs_window_track.sv
module lcs_window_track #(
  parameter int TAP_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp,
  input  logic             hit,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);
  logic [TAP_W-1:0] run_start;
  logic [LEN_W-1:0] run_len;
  logic [LEN_W-1:0] run_next;
  logic [TAP_W-1:0] start_next;

  assign run_next   = run_len + 1'b1;
  assign start_next = (run_len == '0) ? tap : run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_start  <= '0;
      run_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (clr) begin
      run_start  <= '0;
      run_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (smp) begin
      if (hit) begin
        run_len   <= run_next;
        run_start <= start_next;
        // Strictly longer only: the earliest run keeps a tie.
        if (run_next > best_len) begin
          best_len   <= run_next;
          best_start <= start_next;
        end
      end else begin
        run_len <= '0;
      end
    end
  end
endmodule

// File: rtl/lcs_lane_bank.sv
module lcs_lane_bank #(
  parameter int LANES   = 2,
  parameter int TAP_W   = 4,
  parameter int SLIP_W  = 3,
  parameter int DEF_TAP = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [((LANES>1)?$clog2(LANES):1)-1:0] wr_lane,
  input  logic                      tap_we,
  input  logic [TAP_W-1:0]          tap_val,
  input  logic                      slip_we,
  input  logic [SLIP_W-1:0]         slip_val,
  output logic [LANES*TAP_W-1:0]    tap_o,
  output logic [LANES*SLIP_W-1:0]   slip_o
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAP_W-1:0]  tap_r;
    logic [SLIP_W-1:0] slip_r;
    logic              sel;
    assign sel = (wr_lane == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_r  <= TAP_W'(DEF_TAP);
        slip_r <= '0;
      end else begin
        if (tap_we && sel)  tap_r  <= tap_val;
        if (slip_we && sel) slip_r <= slip_val;
      end
    end

    assign tap_o[g*TAP_W +: TAP_W]    = tap_r;
    assign slip_o[g*SLIP_W +: SLIP_W] = slip_r;
  end
endmodule

// File: rtl/lane_cal_seq.sv
module lane_cal_seq
  import lcs_pkg::*;
#(
  parameter int                LANES      = 2,
  parameter int                WORD_W     = 8,
  parameter int                TAPS       = 16,
  parameter int                DEF_TAP    = 8,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hA5,
  parameter int                MIN_WIN    = 3,
  parameter int                SETTLE     = 3,
  parameter int                LAUNCH_MIN = 2,
  parameter int                LAUNCH_MAX = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                pll_locked,
  input  logic                                launch,
  input  logic                                train_ack,
  input  logic [LANES*WORD_W-1:0]             lane_word,
  output logic                                rst_out,
  output logic                                train_req,
  output logic                                dly_tick,
  output logic [LANES*$clog2(TAPS)-1:0]       lane_tap,
  output logic [LANES*((WORD_W>1)?$clog2(WORD_W):1)-1:0] lane_slip,
  output logic                                cal_done,
  output logic                                cal_error
);
  localparam int TAP_W  = $clog2(TAPS);
  localparam int SLIP_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LEN_W  = $clog2(TAPS + 1);
  localparam int SET_W  = $clog2(SETTLE + 1);

  // ---- arithmetic helpers ----
  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int r);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << r;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic is_rotation(input logic [WORD_W-1:0] w);
    logic found;
    found = 1'b0;
    for (int r = 0; r < WORD_W; r++) begin
      if (rotl(TRAIN_WORD, r) == w) found = 1'b1;
    end
    return found;
  endfunction

  function automatic logic [TAP_W-1:0] centre_of(input logic [TAP_W-1:0] start,
                                                 input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] half;
    half = (len - 1'b1) >> 1;
    return start + TAP_W'(half);
  endfunction

  // ---- state ----
  cal_state_e        st, st_n;
  logic [LANE_W-1:0] lane_q;
  logic [TAP_W-1:0]  tap_q;
  logic [SLIP_W-1:0] slip_q;
  logic [SET_W-1:0]  set_q;
  logic [1:0]        div_q;
  logic              rst_out_q;

  // ---- named internal events ----
  logic              tick;
  logic              launch_ok;
  logic              settle_end;
  logic              last_tap, last_slip, last_lane;
  logic [WORD_W-1:0] cur_word;
  logic              word_hit, word_match;
  logic [TAP_W-1:0]  best_start, centre_tap;
  logic [LEN_W-1:0]  best_len;
  logic              win_ok;
  logic              busy_align, wait_ack;
  logic              tap_we, slip_we, win_clr, win_smp, lane_adv;
  logic [TAP_W-1:0]  wr_tap;
  logic [SLIP_W-1:0] wr_slip;

  assign tick       = (div_q == 2'd3);
  assign settle_end = (set_q == SET_W'(SETTLE - 1));
  assign last_tap   = (tap_q == TAP_W'(TAPS - 1));
  assign last_slip  = (slip_q == SLIP_W'(WORD_W - 1));
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));
  assign cur_word   = lane_word[lane_q*WORD_W +: WORD_W];
  assign word_hit   = is_rotation(cur_word);
  assign word_match = (cur_word == TRAIN_WORD);
  assign centre_tap = centre_of(best_start, best_len);
  assign win_ok     = (best_len >= LEN_W'(MIN_WIN));
  assign wait_ack   = (st == S_WAIT_ACK);
  assign busy_align = (st == S_SW_SET) || (st == S_SW_SETTLE) || (st == S_SW_END) ||
                      (st == S_CTR_SET) || (st == S_SL_SETTLE);

  assign rst_out   = rst_out_q;
  assign train_req = wait_ack || busy_align;
  assign dly_tick  = tick;
  assign cal_done  = (st == S_DONE);
  assign cal_error = (st == S_ERR);

  lcs_launch_filter #(.LAUNCH_MIN(LAUNCH_MIN), .LAUNCH_MAX(LAUNCH_MAX)) u_launch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_ok(launch_ok)
  );

  lcs_window_track #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .smp(win_smp), .hit(word_hit),
    .tap(tap_q), .best_start(best_start), .best_len(best_len)
  );

  lcs_lane_bank #(.LANES(LANES), .TAP_W(TAP_W), .SLIP_W(SLIP_W), .DEF_TAP(DEF_TAP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_lane(lane_q),
    .tap_we(tap_we), .tap_val(wr_tap), .slip_we(slip_we), .slip_val(wr_slip),
    .tap_o(lane_tap), .slip_o(lane_slip)
  );

  // ---- sequencing ----
  always_comb begin
    st_n     = st;
    tap_we   = 1'b0;
    slip_we  = 1'b0;
    wr_tap   = tap_q;
    wr_slip  = slip_q;
    win_clr  = 1'b0;
    win_smp  = 1'b0;
    lane_adv = 1'b0;
    if (!pll_locked) begin
      st_n = S_IDLE;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: begin
          if (launch_ok && !rst_out_q) st_n = S_WAIT_ACK;
        end
        S_WAIT_ACK: begin
          if (train_ack) begin
            st_n    = S_SW_SET;
            win_clr = 1'b1;
          end
        end
        default: begin
          if (!train_ack) begin
            st_n = S_IDLE;
          end else begin
            case (st)
              S_SW_SET: begin
                if (tick) begin
                  tap_we = 1'b1;
                  st_n   = S_SW_SETTLE;
                end
              end
              S_SW_SETTLE: begin
                if (settle_end) begin
                  win_smp = 1'b1;
                  st_n    = last_tap ? S_SW_END : S_SW_SET;
                end
              end
              S_SW_END: st_n = win_ok ? S_CTR_SET : S_ERR;
              S_CTR_SET: begin
                if (tick) begin
                  tap_we  = 1'b1;
                  wr_tap  = centre_tap;
                  slip_we = 1'b1;
                  wr_slip = '0;
                  st_n    = S_SL_SETTLE;
                end
              end
              S_SL_SETTLE: begin
                if (settle_end) begin
                  if (word_match) begin
                    if (last_lane) begin
                      st_n = S_DONE;
                    end else begin
                      lane_adv = 1'b1;
                      win_clr  = 1'b1;
                      st_n     = S_SW_SET;
                    end
                  end else if (last_slip) begin
                    st_n = S_ERR;
                  end else begin
                    slip_we = 1'b1;
                    wr_slip = slip_q + 1'b1;
                  end
                end
              end
              default: st_n = S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lane_q    <= '0;
      tap_q     <= '0;
      slip_q    <= '0;
      set_q     <= '0;
      div_q     <= '0;
      rst_out_q <= 1'b1;
    end else begin
      st        <= st_n;
      div_q     <= div_q + 1'b1;
      rst_out_q <= !pll_locked;

      if (st_n == S_WAIT_ACK)   lane_q <= '0;
      else if (lane_adv)        lane_q <= lane_q + 1'b1;

      if (win_clr)                       tap_q <= '0;
      else if (win_smp && !last_tap)     tap_q <= tap_q + 1'b1;

      if (slip_we) slip_q <= wr_slip;

      if (tap_we || slip_we)
        set_q <= '0;
      else if ((st == S_SW_SETTLE || st == S_SL_SETTLE) && !settle_end)
        set_q <= set_q + 1'b1;
    end
  end
endmodule

// File: rtl/lane_cal_seq_chk.sv
module lane_cal_seq_chk #(
  parameter int TAPV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pll_locked,
  input logic              rst_out,
  input logic              train_ack,
  input logic              train_req,
  input logic              dly_tick,
  input logic [TAPV_W-1:0] lane_tap,
  input logic              cal_done,
  input logic              cal_error,
  input logic              busy_align,
  input logic              wait_ack
);
  // R1, R12: losing lock forces the reset output and an idle, flag-free state.
  assert_unlock_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (rst_out && !train_req && !cal_done && !cal_error));

  // R4: no tap movement while the acknowledge is still awaited.
  assert_wait_taps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ack |=> $stable(lane_tap));

  // R5: taps move only on the edge after a quarter-rate tick.
  assert_tick_taps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_tick |=> $stable(lane_tap));

  // R11: acknowledge falling mid-alignment aborts without raising error.
  assert_ack_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_align && !train_ack && pll_locked) |=> (!train_req && !cal_done && !cal_error));

  // R10: done only rises out of an acknowledged alignment.
  assert_done_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(train_ack && train_req));

  // R7, R9: error only rises out of an active request.
  assert_err_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_error) |-> $past(train_req));
endmodule

bind lane_cal_seq lane_cal_seq_chk #(.TAPV_W(LANES*TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .rst_out(rst_out),
  .train_ack(train_ack), .train_req(train_req), .dly_tick(dly_tick),
  .lane_tap(lane_tap), .cal_done(cal_done), .cal_error(cal_error),
  .busy_align(busy_align), .wait_ack(wait_ack)
);

// File: tb/lane_cal_seq_tb.sv
`timescale 1ns/1ps
module lane_cal_seq_tb;
  localparam int NL = 2;
  localparam int WW = 8;
  localparam int TW = 4;
  localparam int SW = 3;
  localparam logic [7:0] TRW = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_locked = 1'b0;
  logic launch = 1'b0;
  logic train_ack = 1'b0;
  logic [NL*WW-1:0] lane_word;
  logic rst_out, train_req, dly_tick, cal_done, cal_error;
  logic [NL*TW-1:0] lane_tap;
  logic [NL*SW-1:0] lane_slip;

  int checks = 0;
  int errors = 0;
  int tick_viol = 0;
  int tap_moves = 0;

  // lane model controls
  logic [15:0] good_mask [NL];
  int          offs [NL];
  logic        stuck [NL];

  always #2 clk = ~clk;

  lane_cal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .launch(launch),
    .train_ack(train_ack), .lane_word(lane_word), .rst_out(rst_out),
    .train_req(train_req), .dly_tick(dly_tick), .lane_tap(lane_tap),
    .lane_slip(lane_slip), .cal_done(cal_done), .cal_error(cal_error)
  );

  function automatic logic [7:0] rot8(input logic [7:0] v, input int r);
    int k;
    k = r % 8;
    if (k == 0) return v;
    return (v << k) | (v >> (8 - k));
  endfunction

  // Lane model: training word appears rotated inside the good taps.
  always_comb begin
    for (int l = 0; l < NL; l++) begin
      int t, s;
      t = int'(lane_tap[l*TW +: TW]);
      s = int'(lane_slip[l*SW +: SW]);
      if (stuck[l])            lane_word[l*WW +: WW] = rot8(TRW, 3);
      else if (good_mask[l][t]) lane_word[l*WW +: WW] = rot8(TRW, offs[l] + s);
      else                     lane_word[l*WW +: WW] = 8'h00;
    end
  end

  // Independent tap-centre model: first longest run of ones.
  function automatic void best_run(input logic [15:0] m, output int st, output int ln);
    st = 0; ln = 0;
    for (int s = 0; s < 16; s++) begin
      int n;
      n = 0;
      while ((s + n) < 16 && m[s + n]) n++;
      if (n > ln) begin ln = n; st = s; end
    end
  endfunction

  function automatic int exp_tap(input logic [15:0] m);
    int st, ln;
    best_run(m, st, ln);
    return st + (ln - 1) / 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5 monitor: tap moves must follow a tick cycle.
  logic [NL*TW-1:0] prev_tap;
  logic prev_tick = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lane_tap !== prev_tap) begin
        tap_moves++;
        if (!prev_tick) tick_viol++;
      end
    end
    prev_tap  <= lane_tap;
    prev_tick <= dly_tick;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    launch = 1'b1;
    cycles(n);
    launch = 1'b0;
  endtask

  task automatic run_cal(input int plen);
    int w;
    pulse(plen);
    cycles(2);
    train_ack = 1'b1;
    w = 0;
    while (!cal_done && !cal_error && w < 4000) begin
      cycles(1);
      w++;
    end
  endtask

  task automatic t_reset();
    check("R1 rst_out in reset", int'(rst_out), 1);
    check("R3 req in reset", int'(train_req), 0);
    check("R10 done in reset", int'(cal_done), 0);
    check("R4 lane0 default tap", int'(lane_tap[0 +: TW]), 8);
    check("R4 lane1 default tap", int'(lane_tap[TW +: TW]), 8);
  endtask

  task automatic t_unlocked_launch();
    pulse(4);
    cycles(3);
    check("R1 launch ignored while unlocked", int'(train_req), 0);
    pll_locked = 1'b1;
    cycles(1);
    check("R1 rst_out falls after lock", int'(rst_out), 0);
    cycles(2);
  endtask

  task automatic t_pulse_widths();
    pulse(1);
    cycles(3);
    check("R2 one-cycle pulse ignored", int'(train_req), 0);
    pulse(17);
    cycles(3);
    check("R2 17-cycle pulse ignored", int'(train_req), 0);
    pulse(2);
    cycles(2);
    check("R2 R3 two-cycle pulse raises request", int'(train_req), 1);
    cycles(60);
    check("R4 lane0 tap held without ack", int'(lane_tap[0 +: TW]), 8);
    check("R4 lane1 tap held without ack", int'(lane_tap[TW +: TW]), 8);
    pll_locked = 1'b0;
    cycles(1);
    check("R12 unlock drops request", int'(train_req), 0);
    check("R12 unlock raises rst_out", int'(rst_out), 1);
    pll_locked = 1'b1;
    cycles(3);
  endtask

  task automatic t_cal_ok();
    good_mask[0] = 16'h03F8; offs[0] = 3; stuck[0] = 1'b0;
    good_mask[1] = 16'h7C00; offs[1] = 0; stuck[1] = 1'b0;
    run_cal(16);
    check("R10 done after alignment", int'(cal_done), 1);
    check("R9 no error", int'(cal_error), 0);
    check("R3 request dropped at done", int'(train_req), 0);
    check("R6 lane0 centre tap", int'(lane_tap[0 +: TW]), exp_tap(good_mask[0]));
    check("R6 lane1 centre tap", int'(lane_tap[TW +: TW]), exp_tap(good_mask[1]));
    check("R8 lane0 slip", int'(lane_slip[0 +: SW]), (8 - offs[0]) % 8);
    check("R8 lane1 slip", int'(lane_slip[SW +: SW]), (8 - offs[1]) % 8);
    train_ack = 1'b0;
    cycles(5);
    check("R10 done held after ack falls", int'(cal_done), 1);
  endtask

  task automatic t_split_windows();
    good_mask[0] = 16'h1F8E; offs[0] = 6;
    good_mask[1] = 16'h0F0F; offs[1] = 1;
    pulse(3);
    cycles(2);
    check("R10 done cleared by new launch", int'(cal_done), 0);
    train_ack = 1'b1;
    for (int w = 0; w < 4000 && !cal_done && !cal_error; w++) cycles(1);
    check("R10 split windows done", int'(cal_done), 1);
    check("R6 widest window chosen", int'(lane_tap[0 +: TW]), exp_tap(good_mask[0]));
    check("R6 tie keeps first window", int'(lane_tap[TW +: TW]), exp_tap(good_mask[1]));
    check("R8 lane0 slip split case", int'(lane_slip[0 +: SW]), (8 - offs[0]) % 8);
    check("R8 lane1 slip split case", int'(lane_slip[SW +: SW]), (8 - offs[1]) % 8);
    train_ack = 1'b0;
    cycles(3);
  endtask

  task automatic t_narrow();
    good_mask[0] = 16'h00F0; offs[0] = 0;
    good_mask[1] = 16'h0C00; offs[1] = 2;
    run_cal(5);
    check("R7 narrow window error", int'(cal_error), 1);
    check("R7 no done on narrow window", int'(cal_done), 0);
    check("R7 request dropped on error", int'(train_req), 0);
    train_ack = 1'b0;
    cycles(3);
  endtask

  task automatic t_stuck();
    good_mask[0] = 16'hFFFF; offs[0] = 0; stuck[0] = 1'b1;
    good_mask[1] = 16'h00F0; offs[1] = 0;
    run_cal(8);
    check("R9 no matching slip error", int'(cal_error), 1);
    check("R9 no done without match", int'(cal_done), 0);
    stuck[0] = 1'b0;
    train_ack = 1'b0;
    cycles(3);
  endtask

  task automatic t_ack_drop();
    good_mask[0] = 16'h03F8; offs[0] = 2;
    good_mask[1] = 16'h03F8; offs[1] = 2;
    pulse(6);
    cycles(2);
    train_ack = 1'b1;
    cycles(40);
    train_ack = 1'b0;
    cycles(2);
    check("R11 abort drops request", int'(train_req), 0);
    check("R11 abort leaves done low", int'(cal_done), 0);
    check("R11 abort leaves error low", int'(cal_error), 0);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      good_mask[l] = 16'h0; offs[l] = 0; stuck[l] = 1'b0;
    end
    cycles(5);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_unlocked_launch();
    t_pulse_widths();
    t_cal_ok();
    t_split_windows();
    t_narrow();
    t_stuck();
    t_ack_drop();
    check("R5 tap writes only after tick", tick_viol, 0);
    check("R5 tap writes observed", int'(tap_moves > 0), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule